// File: doc/BRIEF.md
# Recirculating Serial/Parallel Shift-Store Register

This block pairs a serial shift register with a parallel-out storage register of the same width (16 bits by default). A single serial data line is used both ways: data can be written in one bit at a time, or read back out. On readout the outgoing bit is fed back into the input end of the register, so the contents are kept. A separate store event moves the whole shift register into the storage register, which drives the parallel outputs. The same store event, with the direction select flipped, copies the storage register back into the shift register.

Everything runs in one system clock domain. Shift and store events arrive as single-cycle strobes that are sampled on the rising clock edge. The bidirectional serial line is split into an input, an output and an output enable. An active-low select gates every operation. The storage register has its own asynchronous active-low clear. A synchronous system reset clears only the shift register.

Top module: `shift_store_reg`

## Requirements
- R1: While `rst` is high at a rising edge, the shift register becomes all zeros, and `sio_oe` is low while `rst` is high.
- R2: While `cs_n` is high, `shift_stb` and `store_stb` change neither the shift register nor `q`.
- R3: `sio_oe` is high exactly when `cs_n` is low, `rw` is high and `rst` is low. While it is high, `sio_out` equals shift register bit 15 (the most significant bit). While it is low, `sio_out` is 0.
- R4: Serial load is selected by `cs_n` low and `rw` low. On a `shift_stb` edge in this mode, every bit moves one place toward bit 15, bit 15 is dropped and `sio_in` enters bit 0. After 16 strobes, the first bit written sits in bit 15.
- R5: Serial output is selected by `cs_n` low and `rw` high. On a `shift_stb` edge in this mode, the register shifts toward bit 15 and the old bit 15 re-enters bit 0. Sixteen such strobes give back the original contents.
- R6: With `cs_n` low and `rw` low, a `store_stb` edge copies the shift register into the storage register. The result is visible on `q` after that edge.
- R7: With `cs_n` low and `rw` high, a `store_stb` edge loads the storage register into the shift register.
- R8: When `store_stb` and `shift_stb` arrive in the same cycle with `cs_n` low, no shift takes place. In a copy to storage, `q` receives the value the shift register had before that edge.
- R9: `q` holds its value at every edge where `cs_n` is high or `rw` is high, as long as `clr_n` stays high.
- R10: While `clr_n` is low, `q` is all zeros at once, without waiting for a clock edge. This overrides any store strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous reset of the shift register, active high |
| clr_n | input | 1 | Asynchronous clear of the storage register, active low |
| cs_n | input | 1 | Select, active low; high blocks all operations |
| rw | input | 1 | Direction: 0 = write in / copy to storage, 1 = read out / load from storage |
| shift_stb | input | 1 | Single-cycle shift event |
| store_stb | input | 1 | Single-cycle store event |
| sio_in | input | 1 | Serial data in |
| sio_out | output | 1 | Serial data out (bit 15 while enabled) |
| sio_oe | output | 1 | Output enable for the serial line |
| q | output | 16 | Parallel storage outputs |

## Verification
The assertions expect `cs_n`, `rw`, the strobes and `sio_in` to be stable around the rising clock edge. They also expect `clr_n` to be low or the storage register to be cleared before it is checked. The bench changes every input only on the falling edge and drives `clr_n` low at the start. It changes `cs_n` and `rw` only between strobes, except in the deliberate same-cycle case where both strobes are raised together.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    typedef struct packed {
        logic shift_en;     // advance the shift register
        logic recirc;       // feed the top bit back into bit 0
        logic copy_out;     // shift register -> storage register
        logic load_in;      // storage register -> shift register
        logic oe;           // drive the serial line
    } ssr_ctrl_t;
endpackage

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
    import ssr_pkg::*;
(
    input  logic      rst,
    input  logic      cs_n,
    input  logic      rw,
    input  logic      shift_stb,
    input  logic      store_stb,
    output ssr_ctrl_t ctrl
);
    always_comb begin
        ctrl          = '0;
        ctrl.oe       = !cs_n && rw && !rst;
        ctrl.recirc   = rw;
        if (!cs_n) begin
            ctrl.copy_out = store_stb && !rw;
            ctrl.load_in  = store_stb && rw;
            // a parallel transfer in the same cycle suppresses the shift
            ctrl.shift_en = shift_stb && !store_stb;
        end
    end
endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter
    import ssr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ssr_ctrl_t        ctrl,
    input  logic             sio_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] shift_q
);
    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] shift;
    } sh_state_t;

    sh_state_t st_d, st_q;
    logic      feed_bit;

    always_comb begin
        st_d     = st_q;
        feed_bit = ctrl.recirc ? st_q.shift[TOP] : sio_in;
        if (ctrl.load_in)
            st_d.shift = par_in;
        else if (ctrl.shift_en)
            st_d.shift = {st_q.shift[TOP-1:0], feed_bit};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign shift_q = st_q.shift;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (shift_q == '0));

    a_r5_recirculate: assert property (@(posedge clk) disable iff (rst)
        (ctrl.shift_en && ctrl.recirc) |=>
            (shift_q == {$past(shift_q[TOP-1:0]), $past(shift_q[TOP])}));

    a_r7_load_back: assert property (@(posedge clk) disable iff (rst)
        ctrl.load_in |=> (shift_q == $past(par_in)));
endmodule

// File: rtl/ssr_store.sv
module ssr_store #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] store_q
);
    logic [WIDTH-1:0] store_d;

    always_comb begin
        store_d = store_q;
        if (capture) store_d = d_in;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) store_q <= '0;
        else        store_q <= store_d;
    end

    a_r9_hold_storage: assert property (@(posedge clk) disable iff (!clr_n)
        !capture |=> $stable(store_q));

    a_r10_clear_low: assert property (@(posedge clk)
        !clr_n |-> (store_q == '0));

    a_r6_copy_in: assert property (@(posedge clk) disable iff (!clr_n)
        capture |=> (store_q == $past(d_in)));
endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg
    import ssr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             cs_n,
    input  logic             rw,
    input  logic             shift_stb,
    input  logic             store_stb,
    input  logic             sio_in,
    output logic             sio_out,
    output logic             sio_oe,
    output logic [WIDTH-1:0] q
);
    localparam int TOP = WIDTH - 1;

    ssr_ctrl_t        ctrl;
    logic [WIDTH-1:0] shift_q;

    ssr_ctrl u_ctrl (
        .rst       (rst),
        .cs_n      (cs_n),
        .rw        (rw),
        .shift_stb (shift_stb),
        .store_stb (store_stb),
        .ctrl      (ctrl)
    );

    ssr_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .sio_in  (sio_in),
        .par_in  (q),
        .shift_q (shift_q)
    );

    ssr_store #(.WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .clr_n   (clr_n),
        .capture (ctrl.copy_out),
        .d_in    (shift_q),
        .store_q (q)
    );

    assign sio_oe  = ctrl.oe;
    assign sio_out = ctrl.oe ? shift_q[TOP] : 1'b0;

    a_r2_deselect_holds: assert property (@(posedge clk) disable iff (rst || !clr_n)
        cs_n |=> ($stable(shift_q) && $stable(q)));

    a_r3_oe_off: assert property (@(posedge clk)
        (cs_n || !rw) |-> !sio_oe);

    a_r8_no_shift_on_xfer: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !rw && store_stb && shift_stb) |=> $stable(shift_q));
endmodule

// File: tb/shift_store_reg_tb.sv
module shift_store_reg_tb;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst, clr_n, cs_n, rw, shift_stb, store_stb, sio_in;
    logic sio_out, sio_oe;
    logic [W-1:0] q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model: sh[0] is bit 0
    bit sh[$];
    logic [W-1:0] m_store;

    always #5 clk = ~clk;

    shift_store_reg #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .clr_n(clr_n), .cs_n(cs_n), .rw(rw),
        .shift_stb(shift_stb), .store_stb(store_stb), .sio_in(sio_in),
        .sio_out(sio_out), .sio_oe(sio_oe), .q(q)
    );

    function automatic logic [W-1:0] sh_vec();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[i] = sh[i];
        return v;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        logic exp_oe;
        exp_oe = !cs_n && rw && !rst;
        check("R6/R9/R10 q vs model", q, m_store);
        check("R3 sio_oe", {15'b0, sio_oe}, {15'b0, exp_oe});
        check("R3 sio_out", {15'b0, sio_out}, {15'b0, exp_oe ? logic'(sh[W-1]) : 1'b0});
    endtask

    // one clock: drive at falling edge, model at rising, compare at falling
    task automatic cyc(input logic c, input logic r, input logic s,
                       input logic t, input logic d);
        bit nb;
        cs_n = c; rw = r; shift_stb = s; store_stb = t; sio_in = d;
        @(posedge clk);
        if (rst) begin
            foreach (sh[i]) sh[i] = 0;
        end else if (!c) begin
            if (t) begin
                if (r) for (int i = 0; i < W; i++) sh[i] = m_store[i];
                else   m_store = sh_vec();
            end else if (s) begin
                nb = r ? sh[W-1] : d;
                sh.push_front(nb);
                void'(sh.pop_back());
            end
        end
        if (!clr_n) m_store = '0;
        @(negedge clk);
        compare_all();
    endtask

    task automatic write_word(input logic [W-1:0] v);
        for (int i = W - 1; i >= 0; i--) cyc(0, 0, 1, 0, v[i]);
    endtask

    task automatic idle(); cyc(1, 0, 0, 0, 0); endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < W; i++) sh.push_back(1'b1);
        m_store = '0;
        rst = 1; clr_n = 0; cs_n = 1; rw = 0;
        shift_stb = 0; store_stb = 0; sio_in = 0;
        @(negedge clk);
        cyc(0, 1, 0, 0, 0);                       // R1: oe low under reset
        cyc(1, 0, 0, 0, 0);
        rst = 0; clr_n = 1;
        idle();
        check("R1 reset q", q, '0);
        check("R1 reset oe", {15'b0, sio_oe}, '0);

        // R4 + R6: serial write then copy
        write_word(16'hA5C3);
        cyc(0, 0, 0, 1, 0);
        check("R4/R6 stored word", q, 16'hA5C3);

        // R3: read mode drives bit 15
        cyc(0, 1, 0, 0, 0);
        check("R3 oe in read", {15'b0, sio_oe}, 16'd1);
        check("R3 msb out", {15'b0, sio_out}, 16'd1);

        // R5: 4 recirculating shifts, copy out, expect rotation
        for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, 0);
        cyc(0, 0, 0, 1, 0);
        check("R5 rotate by 4", q, 16'h5C3A);
        // 12 more recirculating shifts restore
        for (int i = 0; i < 12; i++) cyc(0, 1, 1, 0, 0);
        cyc(0, 0, 0, 1, 0);
        check("R5 full turn restores", q, 16'hA5C3);

        // R2: deselected strobes do nothing
        write_word(16'h0F0F);
        cyc(1, 0, 1, 1, 1);
        cyc(1, 1, 1, 1, 0);
        cyc(1, 0, 0, 1, 0);
        check("R2 q unchanged while deselected", q, 16'hA5C3);
        cyc(0, 0, 0, 1, 0);
        check("R2 shift unchanged while deselected", q, 16'h0F0F);

        // R9: store strobe in read direction leaves q (it loads shift instead)
        write_word(16'h1234);
        cyc(0, 1, 0, 1, 0);
        check("R9 q held with rw high", q, 16'h0F0F);
        // R7: shift now holds 0F0F
        cyc(0, 0, 0, 1, 0);
        check("R7 load back from storage", q, 16'h0F0F);

        // R8: both strobes with rw low: copy pre-shift value, no shift
        write_word(16'h8001);
        cyc(0, 0, 1, 1, 1);
        check("R8 copy wins over shift", q, 16'h8001);
        cyc(0, 0, 0, 1, 0);
        check("R8 shift register not advanced", q, 16'h8001);
        // R8 with rw high: load wins, then read msb
        write_word(16'h7FFE);
        cyc(0, 1, 1, 1, 0);
        check("R8/R7 load over recirc msb", {15'b0, sio_out}, 16'd1);

        // R10: async clear, overrides a store strobe
        cs_n = 1; shift_stb = 0; store_stb = 0;
        #1 clr_n = 0;
        #1 check("R10 async clear immediate", q, '0);
        m_store = '0;
        @(negedge clk);
        cyc(0, 0, 0, 1, 0);
        check("R10 clear overrides store", q, '0);
        clr_n = 1;
        cyc(0, 0, 0, 1, 0);
        check("R6 copy after clear", q, 16'h8001);

        // R1: reset mid-run clears shift register
        rst = 1;
        cyc(0, 0, 0, 0, 0);
        rst = 0;
        cyc(0, 0, 0, 1, 0);
        check("R1 shift cleared by reset", q, '0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule